// File: doc/BRIEF.md
# Differential DAC Dither Injector

This block feeds two DAC channels that are wired as one differential output. It takes a signed sample that carries fractional bits below the DAC LSB. It draws two independent uniform random dither values per sample, one common-mode and one differential-mode. Each DAC path sums the signal and both dither terms in a single adder, clamps the sum to the DAC range and drops the fractional bits.

The positive path carries signal + CM + DM. The negative path carries −signal + CM − DM. When an analog difference stage subtracts the two paths, the common-mode term cancels. Only the small differential term stays in the output as added noise, so the common-mode level can be set generously while the differential level is kept just large enough to break up noise modulation.

A mode bit gives the common-mode term a fixed quarter-LSB offset on both paths. Together with a ±0.25 LSB common-mode amplitude, this provides a very small common-mode dither setting.

Top module: `diff_dither_dac`

## Requirements
- R1: After reset, out_valid, out_p, out_n and sat_flag are all 0.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid is high. out_p and out_n update together in that cycle and hold their values in cycles with no accepted sample.
- R3: in_sample is two's complement with FRAC_W (8) fractional bits. With cm_amp = 0, dm_amp = 0 and cm_ofs_en = 0, out_p = floor(in_sample / 256) and out_n = floor(−in_sample / 256).
- R4: With cm_ofs_en = 1, the value 64 (0.25 LSB) is added to both path sums before truncation.
- R5: With dm_amp = 0, cm_ofs_en = 0 and an LSB-aligned input k·256, out_p − out_n = 2k for any cm_amp, provided neither path clamps. The common-mode dither cancels.
- R6: With cm_amp = 0 and cm_ofs_en = 0, the differential dither has opposite sign on the two paths, so out_p + out_n is −1 or 0 when no path clamps.
- R7: cm_amp and dm_amp are unsigned amplitudes in units of 1/256 LSB. Each dither term lies in [−amp, +amp]. Each output therefore lies between the clamped floor((±in_sample − cm_amp − dm_amp)/256) and the clamped floor((±in_sample + cm_amp + dm_amp)/256).
- R8: The two dither sources are 32-bit LFSRs with distinct nonzero seeds. Each advances once per accepted sample. With a nonzero amplitude and a constant input, the output words vary from sample to sample.
- R9: Each path sum is clamped to the signed DAC range [−2^(DAC_W−1), 2^(DAC_W−1)−1], which is [−32768, 32767] by default.
- R10: sat_flag is set when either path clamps on an accepted sample. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_sample | input | DAC_W+FRAC_W | Signed sample with fractional bits |
| cm_amp | input | AMP_W | Common-mode dither amplitude, 1/256 LSB units |
| dm_amp | input | AMP_W | Differential-mode dither amplitude, 1/256 LSB units |
| cm_ofs_en | input | 1 | Add +0.25 LSB to the common-mode term |
| out_valid | output | 1 | Output words updated |
| out_p | output | DAC_W | Positive-path DAC word, signed |
| out_n | output | DAC_W | Negative-path DAC word, signed |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The dither values are pseudo-random, so the hardest part to reach from the ports is showing that the common-mode term really cancels and the differential term really has opposite sign. The stimulus isolates each source in turn. With only common-mode dither active and LSB-aligned inputs, the difference of the two words must be exact. With only differential dither active, the sum of the two words must stay in {−1, 0}. Clamping is reached by driving full-scale inputs with the quarter-LSB offset and with large dither, at both ends of the range.

// File: rtl/diff_dither_dac.sv
module diff_dither_dac #(
  parameter int DAC_W = 16,
  parameter int FRAC_W = 8,
  parameter int AMP_W = 10,
  parameter int RND_W = 12,
  parameter logic [31:0] TAPS = 32'hA300_0000,
  parameter logic [31:0] SEED_CM = 32'h1ACE_B00C,
  parameter logic [31:0] SEED_DM = 32'h5EED_0F17,
  localparam int IN_W = DAC_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic [AMP_W-1:0]        cm_amp,
  input  logic [AMP_W-1:0]        dm_amp,
  input  logic                    cm_ofs_en,
  output logic                    out_valid,
  output logic signed [DAC_W-1:0] out_p,
  output logic signed [DAC_W-1:0] out_n,
  output logic                    sat_flag
);
  localparam int PW = RND_W + AMP_W + 1;
  localparam int DW = AMP_W + 2;
  localparam int SW = IN_W + 3;
  localparam int QW = SW - FRAC_W;
  localparam logic signed [QW-1:0] QMAX = QW'((2 ** (DAC_W - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = -QW'(2 ** (DAC_W - 1));

  logic [31:0] lfsr_cm, lfsr_dm;

  function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] seed);
    logic [31:0] nx;
    nx = s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
    return (nx == '0) ? seed : nx;
  endfunction

  function automatic logic signed [DW-1:0] shape(input logic [RND_W-1:0] r, input logic [AMP_W-1:0] a);
    logic [PW-1:0] prod;
    prod = PW'(r) * PW'({a, 1'b1});
    return $signed({1'b0, prod[PW-1:RND_W]}) - $signed({2'b00, a});
  endfunction

  function automatic logic signed [QW-1:0] sat(input logic signed [QW-1:0] q);
    if (q > QMAX) return QMAX;
    if (q < QMIN) return QMIN;
    return q;
  endfunction

  logic signed [DW-1:0] cm_d, dm_d;
  logic signed [SW-1:0] s_x, cm_x, dm_x, ofs_x, sum_p, sum_n;
  logic signed [QW-1:0] q_p, q_n, c_p, c_n;

  assign cm_d  = shape(lfsr_cm[RND_W-1:0], cm_amp);
  assign dm_d  = shape(lfsr_dm[RND_W-1:0], dm_amp);
  assign s_x   = SW'(in_sample);
  assign cm_x  = SW'(cm_d);
  assign dm_x  = SW'(dm_d);
  assign ofs_x = cm_ofs_en ? SW'(2 ** (FRAC_W - 2)) : '0;
  assign sum_p = s_x + cm_x + ofs_x + dm_x;
  assign sum_n = cm_x + ofs_x - s_x - dm_x;
  assign q_p   = sum_p[SW-1:FRAC_W];
  assign q_n   = sum_n[SW-1:FRAC_W];
  assign c_p   = sat(q_p);
  assign c_n   = sat(q_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_cm   <= SEED_CM;
      lfsr_dm   <= SEED_DM;
      out_valid <= 1'b0;
      out_p     <= '0;
      out_n     <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lfsr_cm <= step(lfsr_cm, SEED_CM);
        lfsr_dm <= step(lfsr_dm, SEED_DM);
        out_p   <= c_p[DAC_W-1:0];
        out_n   <= c_n[DAC_W-1:0];
        if ((c_p != q_p) || (c_n != q_n)) sat_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/diff_dither_dac_chk.sv
module diff_dither_dac_chk #(
  parameter int DAC_W = 16,
  parameter int AMP_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [AMP_W-1:0]        cm_amp,
  input logic                    cm_ofs_en,
  input logic                    out_valid,
  input logic signed [DAC_W-1:0] out_p,
  input logic signed [DAC_W-1:0] out_n,
  input logic                    sat_flag
);
  logic signed [DAC_W:0] pair_sum;
  assign pair_sum = (DAC_W+1)'(out_p) + (DAC_W+1)'(out_n);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_words_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_p) && $stable(out_n)));
  p_sticky_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);
  p_dm_antisym_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cm_amp == '0 && !cm_ofs_en) |=> (pair_sum == 0 || pair_sum == -1 || sat_flag));
endmodule

bind diff_dither_dac diff_dither_dac_chk #(.DAC_W(DAC_W), .AMP_W(AMP_W)) u_chk (.*);

// File: tb/diff_dither_dac_tb.sv
module diff_dither_dac_tb;
  localparam int DAC_W = 16;
  localparam int FRAC_W = 8;
  localparam int AMP_W = 10;
  localparam int IN_W = DAC_W + FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_sample = '0;
  logic [AMP_W-1:0] cm_amp = '0, dm_amp = '0;
  logic cm_ofs_en = 1'b0;
  logic out_valid, sat_flag;
  logic signed [DAC_W-1:0] out_p, out_n;

  always #2 clk = ~clk;

  diff_dither_dac u_dut (.*);

  int total = 0, bad = 0;
  string tag_q[$];
  int mode_q[$];
  longint a_q[$], b_q[$], c_q[$], d_q[$];
  longint pmin, pmax;

  function automatic longint fl(longint x);
    return x >>> FRAC_W;
  endfunction
  function automatic longint clampv(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(longint s, int mode, longint a, longint b, longint c, longint d, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = IN_W'(s);
    tag_q.push_back(tag); mode_q.push_back(mode);
    a_q.push_back(a); b_q.push_back(b); c_q.push_back(c); d_q.push_back(d);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic exact(longint s, string tag);
    longint o;
    o = cm_ofs_en ? 64 : 0;
    send(s, 0, clampv(fl(s + o)), clampv(fl(-s + o)), 0, 0, tag);
  endtask

  task automatic bounded(longint s, string tag);
    longint w;
    w = longint'(cm_amp) + longint'(dm_amp);
    send(s, 3, clampv(fl(s - w)), clampv(fl(s + w)), clampv(fl(-s - w)), clampv(fl(-s + w)), tag);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (mode_q.size() == 0) chk(1'b0, "R2 spurious out_valid", 1, 0);
      else begin
        string t; int m; longint a, b, c, d, p, n;
        t = tag_q.pop_front(); m = mode_q.pop_front();
        a = a_q.pop_front(); b = b_q.pop_front(); c = c_q.pop_front(); d = d_q.pop_front();
        p = longint'(out_p); n = longint'(out_n);
        case (m)
          0: begin chk(p == a, {t, " out_p"}, p, a); chk(n == b, {t, " out_n"}, n, b); end
          1: chk((p + n == 0) || (p + n == -1), {t, " out_p+out_n"}, p + n, 0);
          2: chk(p - n == a, {t, " out_p-out_n"}, p - n, a);
          default: begin
            chk(p >= a && p <= b, {t, " out_p in bound"}, p, a);
            chk(n >= c && n <= d, {t, " out_n in bound"}, n, c);
            if (p < pmin) pmin = p;
            if (p > pmax) pmax = p;
          end
        endcase
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_p == 0 && out_n == 0, "R1 words", out_p, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sat_flag == 1'b0, "R1 sat_flag", sat_flag, 0);

    // R3 plain truncation, back-to-back samples for R2 ordering
    exact(0, "R3"); exact(256 * 100 + 17, "R3"); exact(-1, "R3");
    exact(-(256 * 5) + 200, "R3"); exact(8000000, "R3"); exact(-8000001, "R3");
    drain();
    chk(out_valid == 1'b0, "R2 idle valid", out_valid, 0);
    chk(mode_q.size() == 0, "R2 one result per sample", mode_q.size(), 0);

    // R4 quarter-LSB offset
    cm_ofs_en = 1'b1;
    exact(0, "R4"); exact(200, "R4"); exact(-64, "R4"); exact(-65, "R4"); exact(191, "R4");
    drain();
    cm_ofs_en = 1'b0;

    // R5 common-mode cancellation
    cm_amp = 10'd512;
    for (int i = 0; i < 24; i++) begin
      longint k;
      k = (i % 3 == 0) ? -7 : ((i % 3 == 1) ? 1000 : i);
      send(k * 256, 2, 2 * k, 0, 0, 0, "R5");
    end
    drain();
    cm_amp = '0;

    // R6 differential opposite sign
    dm_amp = 10'd100;
    for (int i = 0; i < 24; i++) send(longint'(i) * 7919 - 90000, 1, 0, 0, 0, 0, "R6");
    drain();

    // R7 bounds, R8 variation
    cm_amp = 10'd300; dm_amp = 10'd30;
    pmin = 1 << 40; pmax = -(1 << 40);
    for (int i = 0; i < 64; i++) bounded(5000, "R7");
    drain();
    chk(pmax > pmin, "R8 dither varies", pmax - pmin, 1);
    cm_amp = '0; dm_amp = '0;

    // R9 clamp, R10 sticky
    chk(sat_flag == 1'b0, "R10 flag clear before clamp", sat_flag, 0);
    cm_ofs_en = 1'b1;
    exact(8388607, "R9 high clamp");
    drain();
    chk(sat_flag == 1'b1, "R10 flag set", sat_flag, 1);
    exact(-8388608, "R9 clamp n path");
    cm_ofs_en = 1'b0;
    exact(256 * 3, "R10 normal sample");
    drain();
    chk(sat_flag == 1'b1, "R10 flag stays", sat_flag, 1);
    cm_amp = 10'd1023; dm_amp = 10'd1023;
    for (int i = 0; i < 8; i++) bounded(-8388608, "R9 low clamp");
    for (int i = 0; i < 8; i++) bounded(8388607, "R9 high dither clamp");
    drain();
    chk(mode_q.size() == 0, "R2 queue empty at end", mode_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule